// File: doc/BRIEF.md
# DAC Power Mode Controller

This block holds the power state of a low-power voltage-output DAC that has its own programmable reference. A serial command unit upstream assembles each frame and hands over a one-cycle strobe, the 4-bit command code and the two most significant data bits. The controller decides from these which of three modes the converter is in: normal (reference and output buffer both running), standby (reference running, output buffer in high impedance) and shutdown (both off). It drives the buffer enable, the reference enable and a 2-bit reference level select for the analog side.

When the converter returns to normal from a low-power mode, its output is not usable at once. The controller drops an output-valid flag and holds it low for a wake-up time counted in clock cycles. That time is longer when leaving shutdown, because the reference must also start, than when leaving standby. Standby can only be entered from normal. The serial path is never gated by this block.

Top module: `dac_power_ctrl`

## Requirements
- R1: After reset the block is in normal mode: buf_en=1, ref_en=1, ref_sel=00 (lowest level), out_valid=1.
- R2: A strobed code 4'b1110 enters shutdown from any mode. In the cycle after the strobe, buf_en=0, ref_en=0 and out_valid=0.
- R3: A strobed code 4'b1100 while in normal enters standby. In the cycle after the strobe, buf_en=0, ref_en=1 and out_valid=0.
- R4: A strobed code 4'b1100 while in shutdown or in standby leaves the mode unchanged. From shutdown, buf_en and ref_en stay 0.
- R5: Each of the codes 4'b1101, 4'b1000, 4'b1001 and 4'b0001 returns the block to normal from standby or shutdown. buf_en=1 and ref_en=1 in the cycle after the strobe.
- R6: After a return to normal from shutdown, out_valid stays low and rises exactly SD_WAKE_CYC clock edges after the edge that took the command.
- R7: After a return to normal from standby, out_valid rises exactly SB_WAKE_CYC edges after the command edge.
- R8: On codes 4'b1100, 4'b1101 and 4'b1110, ref_sel takes ref_bits in the next cycle, even when a 4'b1100 is refused. All other codes leave ref_sel unchanged.
- R9: Codes 4'b0000, 4'b0010 to 4'b0111, 4'b1010, 4'b1011 and 4'b1111, and any code presented with cmd_valid low, change no output.
- R10: A wake code received while already in normal does not restart the wake-up count. A sleep code during the count aborts it, and the next wake starts a full count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_code | input | 4 | Command code of the frame |
| ref_bits | input | 2 | Two upper data bits of the frame (reference level) |
| buf_en | output | 1 | Output buffer enable; 0 means high impedance |
| ref_en | output | 1 | Internal reference enable |
| ref_sel | output | 2 | Reference level select, 00 lowest to 11 highest |
| out_valid | output | 1 | DAC output settled and usable |

## Verification
The bench builds the controller with SD_WAKE_CYC=12 and SB_WAKE_CYC=4. These short windows make it possible to watch every wake-up count run out cycle by cycle. Because the two delays differ, a count loaded from the wrong source is caught at once. The short counts also leave room in the run for several counts that are aborted, restarted or overlapped by further commands. Both values are at least 1, which every wake-up check relies on.

// File: rtl/dpc_pkg.sv
// Shared types and command codes for the DAC power mode controller.
// Assumes the command codes arrive already aligned from the serial unit.
package dpc_pkg;

    typedef enum logic [1:0] {
        PM_NORMAL   = 2'd0,
        PM_STANDBY  = 2'd1,
        PM_SHUTDOWN = 2'd2
    } pm_mode_t;

    localparam logic [3:0] OP_LOAD_IN  = 4'b0001;
    localparam logic [3:0] OP_UPDATE   = 4'b1000;
    localparam logic [3:0] OP_LOAD_ALL = 4'b1001;
    localparam logic [3:0] OP_STANDBY  = 4'b1100;
    localparam logic [3:0] OP_RESUME   = 4'b1101;
    localparam logic [3:0] OP_SHUTDOWN = 4'b1110;

    typedef struct packed {
        logic wake;
        logic to_standby;
        logic to_shutdown;
        logic ref_load;
    } pm_req_t;

endpackage

// File: rtl/dpc_cmd_decode.sv
// Classifies a strobed command code into power requests.
// Assumes: at most one request class per code; unlisted codes yield none.
module dpc_cmd_decode
    import dpc_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    output pm_req_t    req
);

    // Map the code to request flags, gated by the strobe.
    always_comb begin
        req = '0;
        if (cmd_valid) begin
            case (cmd_code)
                OP_LOAD_IN, OP_UPDATE, OP_LOAD_ALL: req.wake = 1'b1;
                OP_RESUME: begin
                    req.wake     = 1'b1;
                    req.ref_load = 1'b1;
                end
                OP_STANDBY: begin
                    req.to_standby = 1'b1;
                    req.ref_load   = 1'b1;
                end
                OP_SHUTDOWN: begin
                    req.to_shutdown = 1'b1;
                    req.ref_load    = 1'b1;
                end
                default: req = '0;
            endcase
        end
    end

endmodule

// File: rtl/dpc_mode_fsm.sv
// Holds the power mode and applies the guarded transitions.
// Assumes requests are mutually exclusive; standby is reachable only
// from normal. Flags a wake-up start whenever normal is re-entered.
module dpc_mode_fsm
    import dpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pm_req_t  req,
    output pm_mode_t mode,
    output logic     wake_start,
    output logic     wake_from_sd
);

    // Mode register with the standby guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= PM_NORMAL;
        end else if (req.to_shutdown) begin
            mode <= PM_SHUTDOWN;
        end else if (req.to_standby && (mode == PM_NORMAL)) begin
            mode <= PM_STANDBY;
        end else if (req.wake) begin
            mode <= PM_NORMAL;
        end
    end

    // A wake counts only when leaving a low-power mode.
    always_comb begin
        wake_start   = req.wake && (mode != PM_NORMAL);
        wake_from_sd = (mode == PM_SHUTDOWN);
    end

endmodule

// File: rtl/dpc_wake_timer.sv
// Down-counter for the settling time after a return to normal.
// Assumes both delays are at least 1 cycle; the count is reloaded on every start.
module dpc_wake_timer #(
    parameter int SD_CYC = 400,
    parameter int SB_CYC = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic from_sd,
    output logic expired
);

    localparam int MAX_CYC = (SD_CYC > SB_CYC) ? SD_CYC : SB_CYC;
    localparam int CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] cnt;

    // Load the delay for the mode being left, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= from_sd ? CW'(SD_CYC) : CW'(SB_CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Expired when no settling time remains.
    always_comb expired = (cnt == '0);

endmodule

// File: rtl/dac_power_ctrl.sv
// Power mode controller for a DAC with a programmable internal reference.
// Assumes one strobe per serial frame; drives the enables, the reference
// level and the output-valid flag. The serial path is not touched here.
module dac_power_ctrl
    import dpc_pkg::*;
#(
    parameter int SD_WAKE_CYC = 400,
    parameter int SB_WAKE_CYC = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    input  logic [1:0] ref_bits,
    output logic       buf_en,
    output logic       ref_en,
    output logic [1:0] ref_sel,
    output logic       out_valid
);

    pm_req_t  req;
    pm_mode_t mode;
    logic     wake_start;
    logic     wake_from_sd;
    logic     settled;

    dpc_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .req       (req)
    );

    dpc_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .mode         (mode),
        .wake_start   (wake_start),
        .wake_from_sd (wake_from_sd)
    );

    dpc_wake_timer #(
        .SD_CYC (SD_WAKE_CYC),
        .SB_CYC (SB_WAKE_CYC)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wake_start),
        .from_sd (wake_from_sd),
        .expired (settled)
    );

    // Reference level register, loaded by the mode-setting codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_sel <= 2'b00;
        end else if (req.ref_load) begin
            ref_sel <= ref_bits;
        end
    end

    // Enables follow the mode; valid needs normal mode and a finished count.
    always_comb begin
        buf_en    = (mode == PM_NORMAL);
        ref_en    = (mode != PM_SHUTDOWN);
        out_valid = buf_en && settled;
    end

endmodule

// File: rtl/dpc_power_ctrl_chk.sv
// Checker for dac_power_ctrl, attached through bind; observes ports only.
module dpc_power_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [3:0] cmd_code,
    input logic [1:0] ref_bits,
    input logic       buf_en,
    input logic       ref_en,
    input logic [1:0] ref_sel,
    input logic       out_valid
);

    logic is_cfg;
    logic is_wake;
    assign is_cfg  = cmd_valid && ((cmd_code == 4'b1100) || (cmd_code == 4'b1101) || (cmd_code == 4'b1110));
    assign is_wake = cmd_valid && ((cmd_code == 4'b1101) || (cmd_code == 4'b1000) ||
                                   (cmd_code == 4'b1001) || (cmd_code == 4'b0001));

    AST_BUF_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en |-> ref_en);                                                     // R3
    AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 4'b1110) |=> (!ref_en && !buf_en && !out_valid)); // R2
    AST_STANDBY_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 4'b1100 && !ref_en) |=> (!ref_en && !buf_en));  // R4
    AST_WAKE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        is_wake |=> (buf_en && ref_en));                                        // R5
    AST_WAKE_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wake && !buf_en) |=> !out_valid);                                   // R6
    AST_REF_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        is_cfg |=> (ref_sel == $past(ref_bits)));                               // R8
    AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_cfg |=> $stable(ref_sel));                                          // R8
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(buf_en) && $stable(ref_en)));                   // R9
    AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && is_wake) |=> out_valid);                                  // R10

endmodule

bind dac_power_ctrl dpc_power_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .ref_bits  (ref_bits),
    .buf_en    (buf_en),
    .ref_en    (ref_en),
    .ref_sel   (ref_sel),
    .out_valid (out_valid)
);

// File: tb/tb_dac_power_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver applies a command, advances a behavioural
// model and queues the expected outputs; the monitor compares on negedge.
module tb_dac_power_ctrl;

    localparam int SD = 12;
    localparam int SB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'b0000;
    logic [1:0] ref_bits = 2'b00;
    logic       buf_en, ref_en, out_valid;
    logic [1:0] ref_sel;

    always #2.5 clk = ~clk;

    dac_power_ctrl #(.SD_WAKE_CYC(SD), .SB_WAKE_CYC(SB)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .ref_bits(ref_bits), .buf_en(buf_en), .ref_en(ref_en),
        .ref_sel(ref_sel), .out_valid(out_valid)
    );

    typedef struct {
        logic       be;
        logic       re;
        logic [1:0] rs;
        logic       ov;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    int   m_mode = 0;   // 0 normal, 1 standby, 2 shutdown
    int   m_cnt  = 0;
    logic [1:0] m_sel = 2'b00;
    bit   done = 1'b0;

    // Present one cycle of input, advance the model, queue the expectation.
    task automatic step(input logic v, input logic [3:0] c, input logic [1:0] b, input string req);
        exp_t e;
        bit   ld;
        cmd_valid = v;
        cmd_code  = c;
        ref_bits  = b;
        @(posedge clk);
        ld = 1'b0;
        if (v) begin
            case (c)
                4'b1110: m_mode = 2;
                4'b1100: if (m_mode == 0) m_mode = 1;
                4'b1101, 4'b1000, 4'b1001, 4'b0001: begin
                    if (m_mode != 0) begin
                        m_cnt  = (m_mode == 2) ? SD : SB;
                        m_mode = 0;
                        ld     = 1'b1;
                    end
                end
                default: ;
            endcase
            if (c == 4'b1100 || c == 4'b1101 || c == 4'b1110) m_sel = b;
        end
        if (!ld && m_cnt > 0) m_cnt--;
        e.be  = (m_mode == 0);
        e.re  = (m_mode != 2);
        e.rs  = m_sel;
        e.ov  = (m_mode == 0) && (m_cnt == 0);
        e.req = req;
        q.push_back(e);
        #1;
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(1'b0, 4'b1110, 2'b11, req);
    endtask

    // Monitor: compare outputs against the queued expectations.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (buf_en !== e.be || ref_en !== e.re || ref_sel !== e.rs || out_valid !== e.ov) begin
                    n_fail++;
                    $display("FAIL %s: got buf_en=%0b ref_en=%0b ref_sel=%0d out_valid=%0b, expected %0b %0b %0d %0b",
                             e.req, buf_en, ref_en, ref_sel, out_valid, e.be, e.re, e.rs, e.ov);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle(2, "R1");
        // wake while already normal, with reference level change
        step(1'b1, 4'b1101, 2'b10, "R10");
        idle(1, "R8");
        // shutdown
        step(1'b1, 4'b1110, 2'b01, "R2");
        idle(2, "R2");
        // standby refused in shutdown, level still loaded
        step(1'b1, 4'b1100, 2'b11, "R4");
        idle(1, "R4");
        // wake from shutdown; data bits of this code must not load the level
        step(1'b1, 4'b1000, 2'b00, "R5");
        idle(SD + 2, "R6");
        // standby from normal
        step(1'b1, 4'b1100, 2'b00, "R3");
        idle(2, "R3");
        step(1'b1, 4'b1100, 2'b01, "R4");
        step(1'b1, 4'b0001, 2'b10, "R5");
        idle(SB + 2, "R7");
        // standby again, wake by 1001
        step(1'b1, 4'b1100, 2'b10, "R3");
        step(1'b1, 4'b1001, 2'b01, "R5");
        idle(SB + 1, "R7");
        // ignored codes
        step(1'b1, 4'b0000, 2'b11, "R9");
        for (int k = 2; k < 8; k++) step(1'b1, 4'(k), 2'b11, "R9");
        step(1'b1, 4'b1010, 2'b11, "R9");
        step(1'b1, 4'b1011, 2'b11, "R9");
        step(1'b1, 4'b1111, 2'b11, "R9");
        step(1'b0, 4'b1110, 2'b11, "R9");
        step(1'b0, 4'b1100, 2'b01, "R9");
        // abort a countdown, then restart
        step(1'b1, 4'b1110, 2'b00, "R2");
        step(1'b1, 4'b1001, 2'b00, "R10");
        idle(5, "R10");
        step(1'b1, 4'b1110, 2'b11, "R10");
        step(1'b1, 4'b1101, 2'b01, "R10");
        idle(3, "R10");
        // wake during a running count must not restart it
        step(1'b1, 4'b1000, 2'b00, "R10");
        idle(SD, "R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule